// File: doc/BRIEF.md
# Cold Reset Sequence Generator

This block produces the power-up cold reset for a chain of devices on a point-to-point link. It waits for a "power and clocks stable" indication. It then raises a power-good output and releases an active-low reset in a fixed order, and each interval is a parameter counted in reference clock cycles. The reset line is shared, open-drain and wired-AND. The block therefore drives it only by pulling it low or letting go. It samples the line back so that any other device on the chain can keep reset asserted for as long as its own initialization needs.

The sequence runs as follows. The block holds reset low from the moment it leaves reset. It then waits a settling interval after the stable input rises, and waits a further lead interval with reset still low. Next it raises power-good and holds reset low for a configurable minimum time. After that it lets go of the line. Completion is reported by a one-cycle pulse, and only once the line has really gone high. If the stable input drops at any point, the block returns to its idle condition and the whole sequence starts again from the beginning.

Top module: `cold_reset_seq`

## Requirements
- R1: While `arst_n` is low and on leaving it, `pwrok` is 0, `rst_drive_low` is 1 (reset pulled low) and `reset_done` is 0.
- R2: Counting the first clock edge that samples `pwr_stable` high as edge 0, `pwrok` rises right after edge (STABLE_MS+LEAD_MS)*MS_CYCLES, and never earlier than STABLE_MS*MS_CYCLES edges of continuous stability.
- R3: `rst_drive_low` is 1 continuously from the moment the stable input is seen until `pwrok` rises, and for at least LEAD_MS*MS_CYCLES cycles immediately before `pwrok` rises.
- R4: After `pwrok` rises, `rst_drive_low` stays 1 for exactly HOLD_MS*MS_CYCLES cycles, and then goes to 0 (line released). HOLD_MS sets this minimum and may be larger than 1.
- R5: `rst_line_in` is sampled by one register. `reset_done` is 1 for the cycle after the first edge in the released state at which that sampled value is 1. An external device that keeps the line low for X extra cycles delays `reset_done` by exactly X cycles.
- R6: `reset_done` pulses only once per sequence. After that pulse, later low levels on `rst_line_in` do not change `pwrok` (stays 1) or `rst_drive_low` (stays 0), and they raise no further pulse.
- R7: An edge that samples `pwr_stable` low sets `pwrok` to 0 and `rst_drive_low` to 1 from the next cycle on. A later rise of `pwr_stable` restarts every interval at its full length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| arst_n | input | 1 | Asynchronous active-low reset of the generator itself |
| pwr_stable | input | 1 | High while supplies and clocks are reported stable |
| pwrok | output | 1 | Power-good output to the chain |
| rst_drive_low | output | 1 | Open-drain enable: 1 pulls the shared reset line low, 0 releases it |
| rst_line_in | input | 1 | Level of the shared reset line (1 = not in reset) |
| reset_done | output | 1 | One-cycle pulse when the released line is first seen high |

## Verification
The bench builds the block with MS_CYCLES = 20, STABLE_MS = 1, LEAD_MS = 1 and HOLD_MS = 2. With these values a full sequence takes under a hundred cycles. That leaves room to repeat it with different external hold lengths and to cut it short in each phase. The hold of two intervals shows that the post-power-good time follows its own parameter rather than the shared interval length. Because the intervals are short, the exact edge of every transition can be compared against a behavioural model on every cycle.

// File: rtl/cold_reset_seq.sv
module cold_reset_seq #(
  parameter int MS_CYCLES = 50000,
  parameter int STABLE_MS = 1,
  parameter int LEAD_MS   = 1,
  parameter int HOLD_MS   = 1
) (
  input  logic clk,
  input  logic arst_n,
  input  logic pwr_stable,
  output logic pwrok,
  output logic rst_drive_low,
  input  logic rst_line_in,
  output logic reset_done
);
  localparam int STABLE_CYC = STABLE_MS * MS_CYCLES;
  localparam int LEAD_CYC   = LEAD_MS * MS_CYCLES;
  localparam int HOLD_CYC   = HOLD_MS * MS_CYCLES;
  localparam int MAX_A      = (STABLE_CYC > LEAD_CYC) ? STABLE_CYC : LEAD_CYC;
  localparam int MAX_CYC    = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int CNT_W      = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {
    IDLE, WAIT_STABLE, PRE_PWROK, HOLD_RESET, RELEASE, RUN
  } state_t;

  state_t           state, timed_next;
  logic [CNT_W-1:0] cnt, limit_m1;
  logic             line_q, done_q;

  always_comb begin
    timed_next = state;
    limit_m1   = '0;
    case (state)
      WAIT_STABLE: begin timed_next = PRE_PWROK;  limit_m1 = CNT_W'(STABLE_CYC - 1); end
      PRE_PWROK:   begin timed_next = HOLD_RESET; limit_m1 = CNT_W'(LEAD_CYC - 1);   end
      HOLD_RESET:  begin timed_next = RELEASE;    limit_m1 = CNT_W'(HOLD_CYC - 1);   end
      default:     ;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state  <= IDLE;
      cnt    <= '0;
      line_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      line_q <= rst_line_in;
      done_q <= 1'b0;
      if (!pwr_stable) begin
        state <= IDLE;
        cnt   <= '0;
      end else begin
        case (state)
          IDLE: begin
            state <= WAIT_STABLE;
            cnt   <= '0;
          end
          WAIT_STABLE, PRE_PWROK, HOLD_RESET: begin
            if (cnt == limit_m1) begin
              state <= timed_next;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RELEASE: begin
            if (line_q) begin
              state  <= RUN;
              done_q <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign pwrok         = (state == HOLD_RESET) || (state == RELEASE) || (state == RUN);
  assign rst_drive_low = (state == IDLE) || (state == WAIT_STABLE) ||
                         (state == PRE_PWROK) || (state == HOLD_RESET);
  assign reset_done    = done_q;
endmodule

// File: rtl/cold_reset_seq_chk.sv
module cold_reset_seq_chk #(
  parameter int MS_CYCLES = 50000,
  parameter int STABLE_MS = 1,
  parameter int LEAD_MS   = 1,
  parameter int HOLD_MS   = 1
) (
  input logic clk,
  input logic arst_n,
  input logic pwr_stable,
  input logic pwrok,
  input logic rst_drive_low,
  input logic rst_line_in,
  input logic reset_done
);
  localparam int unsigned STABLE_CYC = STABLE_MS * MS_CYCLES;
  localparam int unsigned LEAD_CYC   = LEAD_MS * MS_CYCLES;
  localparam int unsigned HOLD_CYC   = HOLD_MS * MS_CYCLES;
  localparam int unsigned SAT        = 32'hFFFF_0000;

  int unsigned stab_run, low_run, pw_run;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stab_run <= 0;
      low_run  <= 0;
      pw_run   <= 0;
    end else begin
      stab_run <= !pwr_stable    ? 0 : (stab_run < SAT ? stab_run + 1 : stab_run);
      low_run  <= !rst_drive_low ? 0 : (low_run  < SAT ? low_run  + 1 : low_run);
      pw_run   <= !pwrok         ? 0 : (pw_run   < SAT ? pw_run   + 1 : pw_run);
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(arst_n) |-> rst_drive_low && !pwrok && !reset_done);

  assert_pwrok_after_stable_R2: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(pwrok) |-> stab_run >= STABLE_CYC + LEAD_CYC);

  assert_reset_lead_R3: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(pwrok) |-> rst_drive_low && low_run >= LEAD_CYC);

  assert_hold_min_R4: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(rst_drive_low) |-> pwrok && pw_run >= HOLD_CYC);

  assert_done_after_line_R5: assert property (@(posedge clk) disable iff (!arst_n)
    reset_done |-> $past(rst_line_in, 2) && !rst_drive_low && pwrok);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!arst_n)
    reset_done |=> !reset_done);

  assert_loss_restart_R7: assert property (@(posedge clk) disable iff (!arst_n)
    !pwr_stable |=> !pwrok && rst_drive_low);
endmodule

bind cold_reset_seq cold_reset_seq_chk #(
  .MS_CYCLES(MS_CYCLES), .STABLE_MS(STABLE_MS), .LEAD_MS(LEAD_MS), .HOLD_MS(HOLD_MS)
) u_chk (
  .clk(clk), .arst_n(arst_n), .pwr_stable(pwr_stable), .pwrok(pwrok),
  .rst_drive_low(rst_drive_low), .rst_line_in(rst_line_in), .reset_done(reset_done)
);

// File: tb/test_cold_reset_seq.sv
module test_cold_reset_seq;
  localparam int MSC = 20, SMS = 1, LMS = 1, HMS = 2;
  localparam int N = SMS * MSC, L = LMS * MSC, H = HMS * MSC;

  logic clk = 1'b0, arst_n = 1'b0, pwr_stable = 1'b0, ext_hold = 1'b0;
  logic pwrok, rst_drive_low, reset_done, rst_line_in;

  assign rst_line_in = !rst_drive_low && !ext_hold;

  cold_reset_seq #(.MS_CYCLES(MSC), .STABLE_MS(SMS), .LEAD_MS(LMS), .HOLD_MS(HMS)) i_cold_reset_seq (
    .clk(clk), .arst_n(arst_n), .pwr_stable(pwr_stable), .pwrok(pwrok),
    .rst_drive_low(rst_drive_low), .rst_line_in(rst_line_in), .reset_done(reset_done));

  always #10 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference, one step per clock edge
  int s = 0; bit fl = 0, lq = 0, e_pw = 0, e_drv = 1, e_done = 0;
  always @(posedge clk) begin
    bit prev_rel, lqo;
    cyc++;
    if (!arst_n) begin
      s = 0; fl = 0; lq = 0; e_done = 0;
    end else begin
      prev_rel = (s >= N + L + H + 1) && !fl;
      lqo = lq;
      lq = !e_drv && !ext_hold;
      if (pwr_stable) begin
        e_done = prev_rel && lqo;
        if (e_done) fl = 1;
        s++;
      end else begin
        s = 0; fl = 0; e_done = 0;
      end
    end
    e_pw  = s >= N + L + 1;
    e_drv = s < N + L + H + 1;
  end

  bit compare_on = 0;
  bit pw_seen, rel_seen, done_seen, low_broken;
  int t_pw, t_rel, t_done, done_count;
  always @(negedge clk) begin
    if (compare_on) begin
      check(pwrok == e_pw, "R2 pwrok vs model", pwrok, e_pw);
      check(rst_drive_low == e_drv, "R4 rst_drive_low vs model", rst_drive_low, e_drv);
      check(reset_done == e_done, "R5 reset_done vs model", reset_done, e_done);
    end
    if (pwr_stable && !pw_seen && !rst_drive_low) low_broken = 1;
    if (pwrok && !pw_seen) begin pw_seen = 1; t_pw = cyc; end
    if (!rst_drive_low && !rel_seen) begin rel_seen = 1; t_rel = cyc; end
    if (reset_done) begin
      done_count++;
      if (!done_seen) begin done_seen = 1; t_done = cyc; end
    end
  end

  task automatic drop_stable();
    @(negedge clk) pwr_stable = 0;
    @(negedge clk);
    check(!pwrok && rst_drive_low, "R7 outputs after loss", {pwrok, rst_drive_low}, 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_seq(input int x);
    int t0;
    pw_seen = 0; rel_seen = 0; done_seen = 0; low_broken = 0; done_count = 0;
    ext_hold = (x > 0);
    @(negedge clk) pwr_stable = 1;
    t0 = cyc + 1;
    while (cyc < t0 + N + L + H + x) @(negedge clk);
    ext_hold = 0;
    repeat (6) @(negedge clk);
    check(pw_seen && t_pw - t0 == N + L, "R2 pwrok rise edge", t_pw - t0, N + L);
    check(!low_broken, "R3 reset low until pwrok", low_broken, 0);
    check(t_pw - t0 - N >= L, "R3 lead before pwrok", t_pw - t0 - N, L);
    check(rel_seen && t_rel - t_pw == H, "R4 hold after pwrok", t_rel - t_pw, H);
    check(done_seen && t_done - t0 == N + L + H + 2 + x, "R5 done delay with external hold",
          t_done - t0, N + L + H + 2 + x);
    check(done_count == 1, "R6 single done pulse", done_count, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!pwrok && rst_drive_low && !reset_done, "R1 during reset",
          {pwrok, rst_drive_low, reset_done}, 3'b010);
    arst_n = 1;
    @(negedge clk);
    check(!pwrok && rst_drive_low && !reset_done, "R1 after reset",
          {pwrok, rst_drive_low, reset_done}, 3'b010);
    compare_on = 1;

    run_seq(0);
    // R6: line pulled low after completion is ignored
    done_count = 0;
    ext_hold = 1;
    repeat (5) @(negedge clk);
    check(pwrok && !rst_drive_low, "R6 outputs with line low after done",
          {pwrok, rst_drive_low}, 2'b10);
    ext_hold = 0;
    repeat (4) @(negedge clk);
    check(done_count == 0, "R6 no extra pulse", done_count, 0);
    drop_stable();

    run_seq(7);
    drop_stable();
    run_seq(1);
    drop_stable();

    // R7: abort during hold, then during the settling wait
    @(negedge clk) pwr_stable = 1;
    repeat (N + L + 3) @(negedge clk);
    check(pwrok && rst_drive_low, "R7 in hold before loss", {pwrok, rst_drive_low}, 2'b11);
    drop_stable();
    @(negedge clk) pwr_stable = 1;
    repeat (N / 2) @(negedge clk);
    drop_stable();
    run_seq(3);
    drop_stable();

    compare_on = 0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    fails++;
    tests++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule